// File: doc/BRIEF.md
# Random Source Command and Status Front End

This block sits between a host register bus and an external entropy source. The host drives it by writing 32-bit command words to a control location and watches its progress through a one-byte code at a status location. A reset command must be followed by release, enable and zeroize, in that order. Zeroize starts a built-in startup self-test over a run of entropy words. The test either clears the block for generation or holds it in a failed state until the next reset command.

Once the host acknowledges a good startup, the block latches one entropy word and reports that a fresh word is ready. The host reads the word from the control location and writes a read acknowledge. That clears the word, and generation stays paused until the host writes enable again. A random word is visible on the bus only while the ready code is shown, so a stale or partial value is never handed out.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, reading offset 0x4 returns status 0x00 and reading offset 0x0 returns zero.
- R2: A write of 0x00000001 to offset 0x0 is accepted in every state. From the next cycle the status is 0xAC, and the random word is cleared to zero.
- R3: The start-up order is strict: 0x00000002 (release) only after the reset command, then 0x80000000 (enable), then 0x80000004 (zeroize), which clears the word and starts the self-test. The status is 0x00 between these steps.
- R4: The self-test consumes exactly TEST_SAMPLES entropy words, one per cycle in which `ent_valid` is high. The status changes to 0x57 (pass) or 0xFA (fail) in the cycle after the clock edge that accepts the last word. Until then it stays 0x00.
- R5: The self-test fails when a run of identical consecutive words is longer than REP_LIMIT. A run of exactly REP_LIMIT words passes.
- R6: The self-test fails when any bit position holds the same value in every sampled word.
- R7: After a pass, 0x80000008 (acknowledge zeroize) starts generation with status 0x00. The next valid entropy word is latched, the status becomes 0xED, and offset 0x0 reads that word.
- R8: In the ready state, 0x8000000F (read acknowledge) sets the status to 0x00 and clears the word. Entropy is then ignored until 0x80000000 (enable) resumes generation of a new word.
- R9: The following leave the status and the random word unchanged: undefined command values, writes to offset 0x4, commands not allowed in the current state, and entropy arriving outside self-test and generation. The failed state is left only by the reset command.
- R10: Offset 0x0 reads zero whenever the status is not 0xED, and offsets other than 0x0 and 0x4 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Command word on a write |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ent_valid | input | 1 | Entropy word valid |
| ent_word | input | 32 | Raw entropy word |

## Verification
The assertions check the following on every cycle:
- the reset command always produces the acknowledge code on the next cycle;
- offset 0x0 never shows a non-zero word unless the ready code is set;
- a ready state can only follow an accepted entropy word in generation;
- a read acknowledge clears the word;
- status-offset writes and the failed state never move the machine;
- the self-test does not finish without entropy.

Only the bench scenarios show the self-test verdicts. These include repeated-word and stuck-bit failures and the pass at exactly the repeat limit. Those scenarios also show that the word read back is the word supplied, and that the enable and acknowledge ordering holds across complete start-up and read cycles.

// File: rtl/rng_cmd_pkg.sv
// Package: shared command words, status codes, phase type and the
// phase-to-status mapping for the random source front end.
package rng_cmd_pkg;

    localparam int WORD_W = 32;

    localparam logic [31:0] CMD_RESET    = 32'h0000_0001;
    localparam logic [31:0] CMD_RELEASE  = 32'h0000_0002;
    localparam logic [31:0] CMD_ENABLE   = 32'h8000_0000;
    localparam logic [31:0] CMD_ZEROIZE  = 32'h8000_0004;
    localparam logic [31:0] CMD_ACK_ZERO = 32'h8000_0008;
    localparam logic [31:0] CMD_READ_ACK = 32'h8000_000F;

    localparam logic [7:0] ST_NONE    = 8'h00;
    localparam logic [7:0] ST_RST_ACK = 8'hAC;
    localparam logic [7:0] ST_OK      = 8'h57;
    localparam logic [7:0] ST_BAD     = 8'hFA;
    localparam logic [7:0] ST_FRESH   = 8'hED;

    typedef enum logic [3:0] {
        PH_OFF, PH_HELD, PH_IDLE, PH_ARMED, PH_TEST,
        PH_PASS, PH_FAIL, PH_GEN, PH_READY, PH_ACKED
    } phase_t;

    typedef struct packed {
        logic rst_cmd;
        logic rel;
        logic enable;
        logic zeroize;
        logic ack_zero;
        logic read_ack;
    } cmd_t;

    // Maps each phase to the one-byte code the host sees.
    function automatic logic [7:0] status_of(phase_t p);
        case (p)
            PH_HELD:  return ST_RST_ACK;
            PH_PASS:  return ST_OK;
            PH_FAIL:  return ST_BAD;
            PH_READY: return ST_FRESH;
            default:  return ST_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rng_cmd_decode.sv
// Command decoder: turns a bus write to the control offset into at most
// one command flag. Assumes commands are whole 32-bit words; anything
// else (or a write elsewhere) yields no flag.
module rng_cmd_decode
    import rng_cmd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFF = 0
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output cmd_t              cmd
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);

    logic hit;

    // Qualify the write and compare against each defined word.
    always_comb begin
        hit          = wr && (addr == CTRL_A);
        cmd          = '0;
        cmd.rst_cmd  = hit && (wdata == CMD_RESET);
        cmd.rel      = hit && (wdata == CMD_RELEASE);
        cmd.enable   = hit && (wdata == CMD_ENABLE);
        cmd.zeroize  = hit && (wdata == CMD_ZEROIZE);
        cmd.ack_zero = hit && (wdata == CMD_ACK_ZERO);
        cmd.read_ack = hit && (wdata == CMD_READ_ACK);
    end
endmodule

// File: rtl/rng_health_check.sv
// Startup health check: streams SAMPLES entropy words and flags a repeat
// run longer than REP_LIMIT or a bit stuck at one value in all samples.
// Assumes the caller asserts clear before a test and gates valid to the
// test window. 'last' marks the final sample; 'pass_now' is the verdict
// including the sample presented in that cycle.
module rng_health_check #(
    parameter int WORD_W    = 32,
    parameter int SAMPLES   = 64,
    parameter int REP_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              valid,
    input  logic [WORD_W-1:0] sample,
    output logic              last,
    output logic              pass_now
);
    localparam int CNT_W = $clog2(SAMPLES + 1);

    logic [CNT_W-1:0]  cnt, run, run_nx;
    logic [WORD_W-1:0] prev, and_acc, or_acc, and_nx, or_nx;
    logic              rep_bad, rep_bad_nx, first, stuck;

    // Next-state of the run length and the bitwise accumulators.
    always_comb begin
        first      = (cnt == '0);
        run_nx     = (!first && sample == prev) ? CNT_W'(run + 1'b1) : CNT_W'(1);
        rep_bad_nx = rep_bad || (run_nx > CNT_W'(REP_LIMIT));
        and_nx     = first ? sample : (and_acc & sample);
        or_nx      = first ? sample : (or_acc | sample);
        stuck      = (|(~or_nx)) || (|and_nx);
        last       = valid && (cnt == CNT_W'(SAMPLES - 1));
        pass_now   = !rep_bad_nx && !stuck;
    end

    // Sample bookkeeping, cleared at the start of each test.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt     <= '0;
            run     <= '0;
            prev    <= '0;
            and_acc <= '0;
            or_acc  <= '0;
            rep_bad <= 1'b0;
        end else if (valid) begin
            cnt     <= CNT_W'(cnt + 1'b1);
            run     <= run_nx;
            prev    <= sample;
            and_acc <= and_nx;
            or_acc  <= or_nx;
            rep_bad <= rep_bad_nx;
        end
    end
endmodule

// File: rtl/rng_word_latch.sv
// Random word holding register: loads one word, clears on request.
// Assumes clear and load are never asked for in the same cycle; clear wins.
module rng_word_latch #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    // Hold, clear or capture the word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) dout <= '0;
        else if (load)       dout <= din;
    end
endmodule

// File: rtl/rng_cmd_ctrl.sv
// Random source command/status front end (top). Decodes host commands,
// sequences reset -> release -> enable -> zeroize/self-test -> generate,
// and hands out one word per read-acknowledge/enable handshake.
// Assumes a single-cycle write strobe and combinational reads.
module rng_cmd_ctrl
    import rng_cmd_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int TEST_SAMPLES = 64,
    parameter int REP_LIMIT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ent_valid,
    input  logic [31:0]       ent_word
);
    localparam int                CTRL_OFF = 0;
    localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(4);

    cmd_t              cmd;
    phase_t            phase, phase_nx;
    logic              word_clr, word_ld, hc_clr, hc_valid, hc_last, hc_pass;
    logic [WORD_W-1:0] word;
    logic [7:0]        status_code;

    rng_cmd_decode #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) u_dec (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .cmd(cmd)
    );

    rng_health_check #(.WORD_W(WORD_W), .SAMPLES(TEST_SAMPLES), .REP_LIMIT(REP_LIMIT)) u_hc (
        .clk(clk), .rst_n(rst_n), .clear(hc_clr), .valid(hc_valid),
        .sample(ent_word), .last(hc_last), .pass_now(hc_pass)
    );

    rng_word_latch #(.WORD_W(WORD_W)) u_word (
        .clk(clk), .rst_n(rst_n), .clear(word_clr), .load(word_ld),
        .din(ent_word), .dout(word)
    );

    // Phase transitions; reset command overrides everything else.
    always_comb begin
        phase_nx = phase;
        word_clr = 1'b0;
        word_ld  = 1'b0;
        hc_clr   = 1'b0;
        hc_valid = 1'b0;
        if (cmd.rst_cmd) begin
            phase_nx = PH_HELD;
            word_clr = 1'b1;
            hc_clr   = 1'b1;
        end else begin
            case (phase)
                PH_HELD:  if (cmd.rel)    phase_nx = PH_IDLE;
                PH_IDLE:  if (cmd.enable) phase_nx = PH_ARMED;
                PH_ARMED: if (cmd.zeroize) begin
                    phase_nx = PH_TEST;
                    word_clr = 1'b1;
                    hc_clr   = 1'b1;
                end
                PH_TEST: begin
                    hc_valid = ent_valid;
                    if (hc_last) phase_nx = hc_pass ? PH_PASS : PH_FAIL;
                end
                PH_PASS:  if (cmd.ack_zero) phase_nx = PH_GEN;
                PH_GEN:   if (ent_valid) begin
                    phase_nx = PH_READY;
                    word_ld  = 1'b1;
                end
                PH_READY: if (cmd.read_ack) begin
                    phase_nx = PH_ACKED;
                    word_clr = 1'b1;
                end
                PH_ACKED: if (cmd.enable) phase_nx = PH_GEN;
                default:  phase_nx = phase;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_OFF;
        else        phase <= phase_nx;
    end

    assign status_code = status_of(phase);

    // Read mux: word only while fresh, status byte, zero elsewhere.
    always_comb begin
        if (bus_addr == CTRL_A)      bus_rdata = (phase == PH_READY) ? word : '0;
        else if (bus_addr == STAT_A) bus_rdata = {24'h0, status_code};
        else                         bus_rdata = '0;
    end
endmodule

// File: rtl/rng_cmd_ctrl_chk.sv
// Checker for rng_cmd_ctrl, attached by bind. Watches bus, entropy input,
// phase, status code and the held word.
module rng_cmd_ctrl_chk
    import rng_cmd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              ent_valid,
    input phase_t            phase,
    input logic [7:0]        status_code,
    input logic [31:0]       word
);
    logic wr_ctrl, wr_stat;
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(4));

    AST_RESET_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata == CMD_RESET) |=> (status_code == ST_RST_ACK)); // R2
    AST_TEST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TEST && !ent_valid && !bus_wr) |=> (phase == PH_TEST)); // R4
    AST_FRESH_FROM_ENTROPY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase == PH_READY) |-> $past(phase == PH_GEN && ent_valid)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READY && wr_ctrl && bus_wdata == CMD_READ_ACK) |=> (phase == PH_ACKED && word == '0)); // R8
    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !ent_valid) |=> $stable(phase)); // R9
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FAIL && !(wr_ctrl && bus_wdata == CMD_RESET)) |=> (phase == PH_FAIL)); // R9
    AST_RAND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0) && status_code != ST_FRESH) |-> (bus_rdata == '0)); // R10
endmodule

bind rng_cmd_ctrl rng_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_valid(ent_valid),
    .phase(phase), .status_code(status_code), .word(word)
);

// File: tb/tb_rng_cmd_ctrl.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks tagged by requirement.
module tb_rng_cmd_ctrl;
    localparam int N   = 16;
    localparam int REP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h04;
    logic [31:0] bus_wdata = '0;
    logic        ent_valid = 1'b0;
    logic [31:0] ent_word = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R1";
    logic [31:0] seed = 32'h1234_5678;

    rng_cmd_ctrl #(.ADDR_W(8), .TEST_SAMPLES(N), .REP_LIMIT(REP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_valid(ent_valid), .ent_word(ent_word)
    );

    always #4 clk = ~clk;

    // Reference model states (plain integers).
    localparam int M_OFF = 0, M_HELD = 1, M_IDLE = 2, M_ARMED = 3, M_TEST = 4;
    localparam int M_PASS = 5, M_FAIL = 6, M_GEN = 7, M_READY = 8, M_ACKED = 9;
    int m_st = M_OFF;
    logic [31:0] m_word = '0;
    logic [31:0] m_q[$];

    function automatic bit m_verdict();
        int run = 1, maxr = 1;
        logic [31:0] a = '1, o = '0;
        for (int i = 0; i < m_q.size(); i++) begin
            if (i > 0 && m_q[i] == m_q[i-1]) run++; else run = 1;
            if (run > maxr) maxr = run;
            a &= m_q[i];
            o |= m_q[i];
        end
        return (maxr <= REP) && (a == 0) && (o == 32'hFFFF_FFFF);
    endfunction

    always @(posedge clk) begin
        bit c;
        c = bus_wr && bus_addr == 8'h00;
        if (!rst_n) begin
            m_st = M_OFF; m_word = '0; m_q.delete();
        end else if (c && bus_wdata == 32'h1) begin
            m_st = M_HELD; m_word = '0;
        end else begin
            case (m_st)
                M_HELD:  if (c && bus_wdata == 32'h2) m_st = M_IDLE;
                M_IDLE:  if (c && bus_wdata == 32'h8000_0000) m_st = M_ARMED;
                M_ARMED: if (c && bus_wdata == 32'h8000_0004) begin
                    m_st = M_TEST; m_word = '0; m_q.delete();
                end
                M_TEST: if (ent_valid) begin
                    m_q.push_back(ent_word);
                    if (m_q.size() == N) m_st = m_verdict() ? M_PASS : M_FAIL;
                end
                M_PASS:  if (c && bus_wdata == 32'h8000_0008) m_st = M_GEN;
                M_GEN:   if (ent_valid) begin m_word = ent_word; m_st = M_READY; end
                M_READY: if (c && bus_wdata == 32'h8000_000F) begin m_st = M_ACKED; m_word = '0; end
                M_ACKED: if (c && bus_wdata == 32'h8000_0000) m_st = M_GEN;
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] m_rdata(logic [7:0] a);
        logic [7:0] s;
        case (m_st)
            M_HELD: s = 8'hAC; M_PASS: s = 8'h57; M_FAIL: s = 8'hFA;
            M_READY: s = 8'hED; default: s = 8'h00;
        endcase
        if (a == 8'h00) return (m_st == M_READY) ? m_word : 32'h0;
        if (a == 8'h04) return {24'h0, s};
        return 32'h0;
    endfunction

    task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
        end
    endtask

    // One clock; compare against the model just after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        chk({tag, " model"}, bus_rdata, m_rdata(bus_addr));
    endtask

    task automatic cmd(logic [31:0] d, logic [7:0] a = 8'h00);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = 8'h04;
    endtask

    task automatic peek(logic [7:0] a, logic [31:0] exp, string t);
        bus_addr = a;
        #1;
        chk(t, bus_rdata, exp);
        bus_addr = 8'h04;
        #1;
    endtask

    task automatic ent(logic [31:0] w);
        ent_valid = 1'b1; ent_word = w;
        tick();
        ent_valid = 1'b0;
        tick();
    endtask

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    // kind 0: pass; 1: run of exactly REP; 2: run of REP+1; 3: bit 5 stuck low.
    task automatic feed(int kind);
        for (int i = 0; i < N; i++) begin
            logic [31:0] w;
            w = rnd();
            if (kind == 3) w = w & ~32'h20;
            else if (i == 0) w = 32'h0;
            else if (i == N - 1) w = 32'hFFFF_FFFF;
            else if (kind == 1 && i < REP) w = 32'h0;
            else if (kind == 2 && i <= REP) w = 32'h0;
            if (i == N - 1) begin
                ent_valid = 1'b1; ent_word = w;
                tick();
                ent_valid = 1'b0;
            end else begin
                ent(w);
                if (i == N - 2) peek(8'h04, 32'h0, "R4");
            end
        end
    endtask

    task automatic startup(int kind);
        tag = "R2";
        cmd(32'h1);
        peek(8'h04, 32'hAC, "R2");
        tag = "R3";
        cmd(32'h8000_0004);
        peek(8'h04, 32'hAC, "R3");
        cmd(32'h2);
        peek(8'h04, 32'h0, "R3");
        cmd(32'h8000_0000);
        cmd(32'h8000_0004);
        peek(8'h04, 32'h0, "R3");
        tag = "R4";
        feed(kind);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        peek(8'h04, 32'h0, "R1");
        peek(8'h00, 32'h0, "R1");
        tag = "R9";
        cmd(32'h8000_0000);
        peek(8'h04, 32'h0, "R9");

        startup(0);
        peek(8'h04, 32'h57, "R4");
        peek(8'h00, 32'h0, "R10");
        peek(8'h08, 32'h0, "R10");

        begin
            logic [31:0] w1, w2;
            tag = "R7";
            cmd(32'h8000_0008);
            peek(8'h04, 32'h0, "R7");
            w1 = rnd();
            ent(w1);
            peek(8'h04, 32'hED, "R7");
            peek(8'h00, w1, "R7");
            tag = "R9";
            ent(~w1);
            peek(8'h00, w1, "R9");
            cmd(32'h8000_0001);
            peek(8'h04, 32'hED, "R9");
            cmd(32'h8000_000F, 8'h04);
            peek(8'h00, w1, "R9");
            tag = "R8";
            cmd(32'h8000_000F);
            peek(8'h04, 32'h0, "R8");
            peek(8'h00, 32'h0, "R8");
            ent(rnd());
            peek(8'h04, 32'h0, "R8");
            cmd(32'h8000_0000);
            w2 = rnd();
            ent(w2);
            peek(8'h00, w2, "R8");
            tag = "R2";
            cmd(32'h1);
            peek(8'h04, 32'hAC, "R2");
            peek(8'h00, 32'h0, "R2");
        end

        startup(2);
        peek(8'h04, 32'hFA, "R5");
        tag = "R9";
        cmd(32'h8000_0008);
        cmd(32'h8000_0000);
        peek(8'h04, 32'hFA, "R9");

        startup(1);
        peek(8'h04, 32'h57, "R5");

        startup(3);
        peek(8'h04, 32'hFA, "R6");

        repeat (4) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule